// File: doc/BRIEF.md
# Bias DAC Write Serializer

This block programs a common-voltage bias DAC over a two-wire, I2C-style link that has no pins of its own. The clock and data lines of that link are two bits of an 8-bit power control register that sits downstream. The serializer therefore expresses every change of line level as a complete register image. It issues that image as a write on a simple register-write port, and then waits a fixed settling time before it sends the next one.

A caller raises `start_i` for one cycle. With it the caller supplies the values for the other six register bits and the 8-bit DAC code. The block then runs the whole transaction on its own: a start condition, the device byte, the sub-address byte, the code byte, and a stop condition. After each byte comes an acknowledge slot, which is only a dummy clock pulse because the slave is never read. `busy_o` stays high for the length of the transaction, and `done_o` marks its end.

Top module: `bias_dac_serializer`

## Requirements
- R1: Every write goes to register address 3. Its data equals the latched base value, except that bit 0 carries the serial clock level and bit 1 carries the serial data level.
- R2: The transaction opens with three writes whose (clock, data) levels are (1,1), then (1,0), then (0,0).
- R3: Each data bit takes three writes: (0,d), then (1,d), then (0,d). Bytes go out most significant bit first.
- R4: After every byte comes an acknowledge slot of three writes with data held at 0: (0,0), (1,0), (0,0). The slave is never sampled.
- R5: The byte order is 0x9C, then 0x00, then the DAC code latched at start. A transaction is exactly 87 writes.
- R6: The transaction closes with three writes whose (clock, data) levels are (0,0), then (1,0), then (1,1).
- R7: After a write is accepted, no further write strobe appears for SETTLE_CYC cycles. When the downstream port is ready, consecutive strobes are exactly SETTLE_CYC+1 cycles apart.
- R8: `wr_strobe_o` lasts one cycle and is high only while `wr_ready_i` is high. While ready is low, the pending write is held with unchanged data.
- R9: A start request that arrives while `busy_o` is high is ignored. The running transaction keeps its original base and code and adds no writes.
- R10: `busy_o` is high from the cycle after a start is accepted until the transaction ends. `done_o` is a single-cycle pulse, with `busy_o` low, SETTLE_CYC+1 cycles after the final stop write when ready is high.
- R11: During and straight after reset, `wr_strobe_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a transaction |
| base_i | input | 8 | Values for the register bits other than clock and data |
| code_i | input | 8 | DAC code for the third byte |
| wr_ready_i | input | 1 | Downstream register port can accept a write |
| wr_addr_o | output | 8 | Register address of the write (constant 3) |
| wr_data_o | output | 8 | Register image for the write |
| wr_strobe_o | output | 1 | Single-cycle write strobe |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Single-cycle end-of-transaction pulse |

## Verification
The bench compares every write image with an independently built list of line levels, using base values whose bits 0 and 1 are set. A design that leaked the caller's bits into the line positions, or that sent LSB first, would therefore show a mismatched image. It drops the ready signal at random and also holds it low for long stretches. A design that strobed without ready, or that moved on while a write was held, would lose or duplicate writes, and the write count of 87 catches that. A second start issued mid-transaction with inverted base and code exposes a block that re-latches its inputs or restarts. The spacing between strobes, and between the last strobe and `done_o`, is measured so that an off-by-one in the settle counter shows up.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ISSUE  = 2'd1,
      ST_SETTLE = 2'd2
   } dbs_state_e;

   typedef struct packed {
      logic scl;
      logic sda;
   } line_pair_t;

   localparam int unsigned BYTE_W        = 8;
   localparam int unsigned WR_PER_BIT    = 3;
   localparam int unsigned BITS_PER_SLOT = BYTE_W + 1;
   localparam int unsigned NUM_SLOTS     = 3;
   localparam int unsigned COND_WR       = 3;
   localparam int unsigned SLOT_WR       = BITS_PER_SLOT * WR_PER_BIT;
   localparam int unsigned TOTAL_WR      = 2 * COND_WR + NUM_SLOTS * SLOT_WR;
   localparam int unsigned STEP_W        = $clog2(TOTAL_WR);

endpackage

// File: rtl/dbs_settle_timer.sv
module dbs_settle_timer #(
   parameter int unsigned SETTLE_CYC = 1250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic zero_o
);

   generate
      if (SETTLE_CYC < 1) begin : g_bad
         $error("SETTLE_CYC must be at least 1");
      end

      if (SETTLE_CYC == 1) begin : g_none
         assign zero_o = 1'b1;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(SETTLE_CYC);
         localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYC - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load_i) begin
               cnt_q <= RELOAD;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign zero_o = (cnt_q == '0);

         // R7: a fresh load always opens a non-empty settling window
         p_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
            load_i |=> !zero_o);
      end
   endgenerate

endmodule

// File: rtl/dbs_line_sequencer.sv
module dbs_line_sequencer
   import dbs_pkg::*;
#(
   parameter logic [7:0] DEV_BYTE = 8'h9C,
   parameter logic [7:0] SUB_BYTE = 8'h00
) (
   input  logic [STEP_W-1:0] step_i,
   input  logic [7:0]        code_i,
   output line_pair_t        lines_o
);

   localparam logic [STEP_W-1:0] STOP_FIRST = STEP_W'(TOTAL_WR - COND_WR);

   logic [STEP_W-1:0] k;
   logic [1:0]        slot;
   logic [STEP_W-1:0] r;
   logic [3:0]        bit_idx;
   logic [1:0]        sub;
   logic [7:0]        cur_byte;
   logic              d;

   always_comb begin
      k        = step_i - STEP_W'(COND_WR);
      slot     = 2'(k / STEP_W'(SLOT_WR));
      r        = k % STEP_W'(SLOT_WR);
      bit_idx  = 4'(r / STEP_W'(WR_PER_BIT));
      sub      = 2'(r % STEP_W'(WR_PER_BIT));
      case (slot)
         2'd0:    cur_byte = DEV_BYTE;
         2'd1:    cur_byte = SUB_BYTE;
         default: cur_byte = code_i;
      endcase
      d = (bit_idx < 4'(BYTE_W)) ? cur_byte[3'(4'd7 - bit_idx)] : 1'b0;

      if (step_i < STEP_W'(COND_WR)) begin
         // opening condition: data falls while clock high, then clock falls
         lines_o.scl = (step_i != STEP_W'(2));
         lines_o.sda = (step_i == STEP_W'(0));
      end else if (step_i >= STOP_FIRST) begin
         // closing condition: clock rises, then data rises while clock high
         lines_o.scl = (step_i != STOP_FIRST);
         lines_o.sda = (step_i == STOP_FIRST + STEP_W'(2));
      end else begin
         lines_o.scl = (sub == 2'd1);
         lines_o.sda = d;
      end
   end

endmodule

// File: rtl/bias_dac_serializer.sv
module bias_dac_serializer
   import dbs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned REG_ADDR   = 3,
   parameter int unsigned CLK_BIT    = 0,
   parameter int unsigned DAT_BIT    = 1,
   parameter int unsigned SETTLE_CYC = 1250,
   parameter logic [7:0]  DEV_BYTE   = 8'h9C,
   parameter logic [7:0]  SUB_BYTE   = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] base_i,
   input  logic [7:0]        code_i,
   input  logic              wr_ready_i,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              wr_strobe_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL_WR - 1);

   generate
      if (CLK_BIT == DAT_BIT) begin : g_bad_bits
         $error("clock and data bit positions must differ");
      end
      if (CLK_BIT >= DATA_W || DAT_BIT >= DATA_W) begin : g_bad_pos
         $error("line bit positions exceed DATA_W");
      end
      if (REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("REG_ADDR does not fit ADDR_W");
      end
   endgenerate

   dbs_state_e        state_q;
   logic [STEP_W-1:0] step_q;
   logic [DATA_W-1:0] base_q;
   logic [7:0]        code_q;
   logic              done_q;
   logic              settle_zero;
   line_pair_t        lines;

   dbs_line_sequencer #(
      .DEV_BYTE (DEV_BYTE),
      .SUB_BYTE (SUB_BYTE)
   ) u_seq (
      .step_i  (step_q),
      .code_i  (code_q),
      .lines_o (lines)
   );

   dbs_settle_timer #(
      .SETTLE_CYC (SETTLE_CYC)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (wr_strobe_o),
      .zero_o (settle_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         base_q  <= '0;
         code_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  base_q  <= base_i;
                  code_q  <= code_i;
                  step_q  <= '0;
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (wr_ready_i) state_q <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (settle_zero) begin
                  if (step_q == LAST_STEP) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     step_q  <= step_q + 1'b1;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      wr_data_o          = base_q;
      wr_data_o[CLK_BIT] = lines.scl;
      wr_data_o[DAT_BIT] = lines.sda;
   end

   assign wr_addr_o   = ADDR_W'(REG_ADDR);
   assign wr_strobe_o = (state_q == ST_ISSUE) && wr_ready_i;
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;

   // R8: a held write keeps its image until the port takes it
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ISSUE && !wr_ready_i) |=> (state_q == ST_ISSUE && $stable(wr_data_o)));

   // R7: strobes never come back to back
   p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_o |=> !wr_strobe_o);

   // R10: done is a lone pulse outside a transaction
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R9: a request during a transaction leaves the latched operands alone
   p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(base_q) && $stable(code_q)));

   // R11: nothing is written while idle
   p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !wr_strobe_o);

endmodule

// File: tb/sim_bias_dac_serializer.sv
`timescale 1ns/1ps
module sim_bias_dac_serializer;

   localparam int S     = 6;
   localparam int NWR   = 87;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] base_i = 8'h00;
   logic [7:0] code_i = 8'h00;
   logic       wr_ready_i = 1'b1;
   logic [7:0] wr_addr_o;
   logic [7:0] wr_data_o;
   logic       wr_strobe_o;
   logic       busy_o;
   logic       done_o;

   always #4 clk = ~clk;

   bias_dac_serializer #(.SETTLE_CYC(S)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
      .code_i(code_i), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .wr_strobe_o(wr_strobe_o), .busy_o(busy_o),
      .done_o(done_o));

   int   vec_count = 0;
   int   miss_count = 0;
   int   cyc = 0;
   int   last_evt = 0;
   int   wcount = 0;
   int   ready_mode = 0;
   bit   done_seen = 1'b0;
   bit   prev_done = 1'b0;
   bit   finished = 1'b0;
   logic [7:0] exp_base = 8'h00;
   logic [7:0] exp_code = 8'h00;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vec_count++;
      if (!ok) begin
         miss_count++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [7:0] exp_img(input logic [7:0] b, input logic [7:0] c, input int idx);
      logic sc[NWR];
      logic sd[NWR];
      logic [7:0] bytes[3];
      int n;
      logic d;
      bytes[0] = 8'h9C; bytes[1] = 8'h00; bytes[2] = c;
      n = 0;
      sc[n] = 1; sd[n] = 1; n++;
      sc[n] = 1; sd[n] = 0; n++;
      sc[n] = 0; sd[n] = 0; n++;
      for (int j = 0; j < 3; j++) begin
         for (int i = 0; i < 9; i++) begin
            d = (i < 8) ? bytes[j][7-i] : 1'b0;
            sc[n] = 0; sd[n] = d; n++;
            sc[n] = 1; sd[n] = d; n++;
            sc[n] = 0; sd[n] = d; n++;
         end
      end
      sc[n] = 0; sd[n] = 0; n++;
      sc[n] = 1; sd[n] = 0; n++;
      sc[n] = 1; sd[n] = 1; n++;
      return {b[7:2], sd[idx], sc[idx]};
   endfunction

   function automatic string phase_req(input int idx);
      if (idx < 3) return "R2";
      if (idx >= NWR - 3) return "R6";
      if (((idx - 3) % 27) >= 24) return "R4";
      return "R3";
   endfunction

   // ready driver, changes away from the sampling edge
   always @(posedge clk) begin
      #2;
      if (ready_mode == 0) wr_ready_i = 1'b1;
      else if (ready_mode == 2) wr_ready_i = 1'b0;
      else wr_ready_i = (($urandom % 4) != 0);
   end

   // monitor samples on the falling edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) begin
         if (wr_strobe_o) begin
            chk(wr_ready_i == 1'b1, "R8", int'(wr_ready_i), 1);
            chk(busy_o == 1'b1, "R10", int'(busy_o), 1);
            chk(wr_addr_o == 8'h03, "R1", int'(wr_addr_o), 3);
            if (wcount < NWR) begin
               chk(wr_data_o == exp_img(exp_base, exp_code, wcount),
                   (wcount == 0) ? "R1" : phase_req(wcount),
                   int'(wr_data_o), int'(exp_img(exp_base, exp_code, wcount)));
            end else begin
               chk(1'b0, "R5", wcount + 1, NWR);
            end
            if (wcount > 0) begin
               if (ready_mode == 0) chk((cyc - last_evt) == S + 1, "R7", cyc - last_evt, S + 1);
               else chk((cyc - last_evt) >= S + 1, "R7", cyc - last_evt, S + 1);
            end
            last_evt = cyc;
            wcount++;
         end
         if (done_o) begin
            chk(wcount == NWR, "R5", wcount, NWR);
            chk(busy_o == 1'b0, "R10", int'(busy_o), 0);
            chk(!prev_done, "R10", int'(prev_done), 0);
            if (ready_mode == 0) chk((cyc - last_evt) == S + 1, "R10", cyc - last_evt, S + 1);
            done_seen = 1'b1;
         end
         prev_done = done_o;
      end
   end

   task automatic run_txn(input logic [7:0] b, input logic [7:0] c, input bit interfere);
      @(posedge clk); #2;
      exp_base = b; exp_code = c; wcount = 0; done_seen = 1'b0;
      start_i = 1'b1; base_i = b; code_i = c;
      @(posedge clk); #2;
      start_i = 1'b0; base_i = 8'($urandom); code_i = 8'($urandom);
      chk(busy_o == 1'b1, "R10", int'(busy_o), 1);
      if (interfere) begin
         // R9: second request mid-flight with different operands
         repeat (40) @(posedge clk);
         #2;
         start_i = 1'b1; base_i = ~b; code_i = ~c;
         @(posedge clk); #2;
         start_i = 1'b0;
      end
      while (!done_seen) @(posedge clk);
      #2;
      chk(wcount == NWR, interfere ? "R9" : "R5", wcount, NWR);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         miss_count++;
         vec_count++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", vec_count, miss_count);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #2;
      // R11: outputs quiet while in reset
      chk(wr_strobe_o == 0, "R11", int'(wr_strobe_o), 0);
      chk(busy_o == 0, "R11", int'(busy_o), 0);
      chk(done_o == 0, "R11", int'(done_o), 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #2;
      chk(wr_strobe_o == 0 && busy_o == 0 && done_o == 0, "R11",
          int'({wr_strobe_o, busy_o, done_o}), 0);

      // directed: ready always high, base bits 0/1 set to probe masking (R1)
      ready_mode = 0;
      run_txn(8'hFF, 8'h00, 1'b0);
      run_txn(8'h03, 8'hFF, 1'b0);
      run_txn(8'hA6, 8'h55, 1'b0);
      run_txn(8'h5B, 8'h7D, 1'b1);   // R9 with exact spacing

      // random ready
      ready_mode = 1;
      for (int t = 0; t < 4; t++) run_txn(8'($urandom), 8'($urandom), 1'b0);
      run_txn(8'($urandom), 8'($urandom), 1'b1);

      // R8: long ready-low stretch in mid-transaction
      fork
         run_txn(8'hC3, 8'h81, 1'b0);
         begin
            repeat (100) @(posedge clk);
            ready_mode = 2;
            repeat (30) @(posedge clk);
            #3;
            chk(busy_o == 1'b1 && wcount < NWR, "R8", wcount, NWR - 1);
            ready_mode = 1;
         end
      join

      repeat (S + 4) @(posedge clk);
      #2;
      chk(busy_o == 0 && done_o == 0, "R10", int'({busy_o, done_o}), 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_count, miss_count);
      $finish;
   end

endmodule